// File: doc/BRIEF.md
# Hamming 7-4 Encoder and Single-Error Corrector

This block holds two independent single-error-correcting paths for 4-bit data. The encode path turns a 4-bit data word into a 7-bit codeword with three parity bits placed among the data bits. The correct path takes a received 7-bit word and computes a 3-bit syndrome. It inverts the single bit that the syndrome points to and returns the repaired 4-bit data, the syndrome and an error flag.

The parity equations do not follow the textbook position-numbered scheme. A nonzero syndrome therefore cannot be read as the position of the bad bit. The corrector matches the syndrome against the signature of each codeword bit instead, and the signatures are derived from the parity equations themselves.

Each path ends in one registered valid/ready stage. A word accepted on a clock edge appears at the output on that edge. It is held there until the consumer takes it. Both paths can be used in the same cycle without affecting each other.

Top module: `ham74_codec`

## Requirements
- R1: Codeword bit 6 down to bit 0 holds D3, D2, D1, Pa, D0, Pb, Pc, where Pa = D3^D2^D1, Pb = D3^D2^D0 and Pc = D2^D1^D0. For example, data 1011 encodes to 1010100.
- R2: While the encode output is valid and not taken, the codeword and its valid flag stay unchanged, and enc_in_ready is low.
- R3: The syndrome is {S2,S1,S0}, where S2 = bit6^bit5^bit4^bit3, S1 = bit6^bit5^bit2^bit1 and S0 = bit5^bit4^bit2^bit0. A valid codeword gives syndrome 000, and its data passes through unchanged.
- R4: A single flipped bit is repaired using these signatures: bit6→110, bit5→111, bit4→101, bit3→100, bit2→011, bit1→010, bit0→001. The output data is {bit6,bit5,bit4,bit2} of the repaired word.
- R5: dec_out_err is 1 exactly when the reported syndrome is nonzero.
- R6: The received word 1000100 gives syndrome 101 and data 1011.
- R7: Each stage has in_ready = !out_valid || out_ready. A word accepted at a clock edge is presented with out_valid high right after that edge.
- R8: After synchronous reset (rst_n low at a clock edge), both output valids are 0 and both input readies are 1.
- R9: While the correct path output is stalled, no new input is accepted, and the data, syndrome and flag already presented stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_in_valid | input | 1 | Data word offered to the encoder |
| enc_in_ready | output | 1 | Encoder stage can take a word |
| enc_in_data | input | 4 | Data bits D3..D0 |
| enc_out_valid | output | 1 | Codeword presented |
| enc_out_ready | input | 1 | Consumer takes the codeword |
| enc_out_code | output | 7 | Codeword, bit 6 first |
| dec_in_valid | input | 1 | Received word offered |
| dec_in_ready | output | 1 | Corrector stage can take a word |
| dec_in_code | input | 7 | Received 7-bit word |
| dec_out_valid | output | 1 | Correction result presented |
| dec_out_ready | input | 1 | Consumer takes the result |
| dec_out_data | output | 4 | Repaired data D3..D0 |
| dec_out_synd | output | 3 | Syndrome {S2,S1,S0} |
| dec_out_err | output | 1 | Syndrome was nonzero |

## Verification
The encoder is driven with fixed words: all zeros, all ones, single-bit data and the worked example. These separate a wrong parity equation from a wrong bit placement. The corrector gets clean codewords, which show that nothing is flipped when the syndrome is zero. It then gets every one of the 16 data values with each of the 7 single-bit flips. The 112 cases tell apart every signature, and they catch a corrector that treats the syndrome as a position. Stall and reset sequences separate a stage that holds its word from one that drops it or overwrites it.

// File: rtl/ham74_pkg.sv
// Package: ham74_pkg
// Shared sizes, codeword bit positions and the parity/syndrome functions
// used by both the encode and the correct paths.
// Assumes the fixed 7/4 layout: bit 6..0 = D3 D2 D1 Pa D0 Pb Pc.
package ham74_pkg;

    localparam int DATA_W = 4;
    localparam int CODE_W = 7;
    localparam int SYND_W = 3;

    // Codeword bit positions (neighbours decode these)
    localparam int POS_D3 = 6;
    localparam int POS_D2 = 5;
    localparam int POS_D1 = 4;
    localparam int POS_PA = 3;
    localparam int POS_D0 = 2;
    localparam int POS_PB = 1;
    localparam int POS_PC = 0;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SYND_W-1:0] synd_t;

    // Build a codeword from four data bits
    function automatic code_t build_code(input data_t d);
        code_t c;
        c         = '0;
        c[POS_D3] = d[3];
        c[POS_D2] = d[2];
        c[POS_D1] = d[1];
        c[POS_D0] = d[0];
        c[POS_PA] = d[3] ^ d[2] ^ d[1];
        c[POS_PB] = d[3] ^ d[2] ^ d[0];
        c[POS_PC] = d[2] ^ d[1] ^ d[0];
        return c;
    endfunction

    // Syndrome of any 7-bit word; zero for a valid codeword
    function automatic synd_t calc_synd(input code_t c);
        synd_t s;
        s[2] = c[POS_D3] ^ c[POS_D2] ^ c[POS_D1] ^ c[POS_PA];
        s[1] = c[POS_D3] ^ c[POS_D2] ^ c[POS_D0] ^ c[POS_PB];
        s[0] = c[POS_D2] ^ c[POS_D1] ^ c[POS_D0] ^ c[POS_PC];
        return s;
    endfunction

    // Data field of a codeword
    function automatic data_t pick_data(input code_t c);
        return {c[POS_D3], c[POS_D2], c[POS_D1], c[POS_D0]};
    endfunction

endpackage

// File: rtl/ham74_stage.sv
// Module: ham74_stage
// One registered valid/ready stage. It takes a word when empty or when its
// current word is being taken at the same edge.
// Assumes the consumer may stall indefinitely; no skid storage.
module ham74_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_word,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_word
);

    logic             vld_q;
    logic [WIDTH-1:0] word_q;
    logic             take;

    // Ready when empty or draining this cycle
    always_comb begin
        in_ready = !vld_q || out_ready;
        take     = in_valid && in_ready;
    end

    // Valid flag: set on accept, cleared once taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else if (take) begin
            vld_q <= 1'b1;
        end else if (out_ready) begin
            vld_q <= 1'b0;
        end
    end

    // Payload register: load only on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (take) begin
            word_q <= in_word;
        end
    end

    assign out_valid = vld_q;
    assign out_word  = word_q;

    // R7
    accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_word == $past(in_word)));

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R8
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && in_ready));

endmodule

// File: rtl/ham74_enc_core.sv
// Module: ham74_enc_core
// Combinational encoder: places data and the three parity bits into the
// 7-bit codeword. Assumes the layout fixed in ham74_pkg.
module ham74_enc_core
    import ham74_pkg::*;
(
    input  data_t data_i,
    output code_t code_o
);

    // Form the codeword from the parity equations
    always_comb begin
        code_o = build_code(data_i);
    end

endmodule

// File: rtl/ham74_fix_core.sv
// Module: ham74_fix_core
// Combinational corrector: computes the syndrome, compares it with the
// signature of every codeword bit and inverts the one that matches.
// Assumes at most one bit in error; a double error is miscorrected.
module ham74_fix_core
    import ham74_pkg::*;
(
    input  code_t rx_i,
    output data_t data_o,
    output synd_t synd_o,
    output logic  err_o
);

    synd_t             synd;
    logic [CODE_W-1:0] flip;
    code_t             fixed;

    // Syndrome of the received word
    always_comb begin
        synd = calc_synd(rx_i);
    end

    // One comparator per bit; signature is the syndrome of that bit alone
    for (genvar i = 0; i < CODE_W; i++) begin : g_sig
        localparam code_t UNIT = code_t'(1) << i;
        localparam synd_t SIG  = calc_synd(UNIT);
        assign flip[i] = (synd == SIG);
    end

    // Apply the correction and extract the outputs
    always_comb begin
        fixed  = rx_i ^ flip;
        data_o = pick_data(fixed);
        synd_o = synd;
        err_o  = (synd != '0);
    end

    // R4
    one_flip_chk: assert final ($onehot0(flip));

    // R3
    clean_pass_chk: assert final ((synd != '0) || (fixed == rx_i));

    // R4
    repaired_ok_chk: assert final (calc_synd(fixed) == '0);

endmodule

// File: rtl/ham74_codec.sv
// Module: ham74_codec
// Top: an encode path and a correct path, each a combinational core
// followed by one valid/ready register stage. The paths are independent.
// Assumes a single clock and synchronous active-low reset.
module ham74_codec
    import ham74_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_in_valid,
    output logic              enc_in_ready,
    input  logic [DATA_W-1:0] enc_in_data,
    output logic              enc_out_valid,
    input  logic              enc_out_ready,
    output logic [CODE_W-1:0] enc_out_code,
    input  logic              dec_in_valid,
    output logic              dec_in_ready,
    input  logic [CODE_W-1:0] dec_in_code,
    output logic              dec_out_valid,
    input  logic              dec_out_ready,
    output logic [DATA_W-1:0] dec_out_data,
    output logic [SYND_W-1:0] dec_out_synd,
    output logic              dec_out_err
);

    localparam int RES_W = DATA_W + SYND_W + 1;

    code_t             enc_code;
    data_t             fix_data;
    synd_t             fix_synd;
    logic              fix_err;
    logic [RES_W-1:0]  res_in;
    logic [RES_W-1:0]  res_out;

    ham74_enc_core u_enc (
        .data_i (enc_in_data),
        .code_o (enc_code)
    );

    ham74_stage #(.WIDTH(CODE_W)) u_enc_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (enc_in_valid),
        .in_ready  (enc_in_ready),
        .in_word   (enc_code),
        .out_valid (enc_out_valid),
        .out_ready (enc_out_ready),
        .out_word  (enc_out_code)
    );

    ham74_fix_core u_fix (
        .rx_i   (dec_in_code),
        .data_o (fix_data),
        .synd_o (fix_synd),
        .err_o  (fix_err)
    );

    // Pack the correction result for the stage
    always_comb begin
        res_in = {fix_data, fix_synd, fix_err};
    end

    ham74_stage #(.WIDTH(RES_W)) u_fix_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (dec_in_valid),
        .in_ready  (dec_in_ready),
        .in_word   (res_in),
        .out_valid (dec_out_valid),
        .out_ready (dec_out_ready),
        .out_word  (res_out)
    );

    // Unpack the registered result onto the ports
    always_comb begin
        dec_out_data = res_out[RES_W-1 -: DATA_W];
        dec_out_synd = res_out[1 +: SYND_W];
        dec_out_err  = res_out[0];
    end

    // R1
    enc_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_out_valid |-> (calc_synd(enc_out_code) == '0));

    // R5
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid |-> (dec_out_err == (dec_out_synd != '0)));

endmodule

// File: tb/ham74_codec_tb_top.sv
module ham74_codec_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_in_valid = 1'b0;
    logic       enc_in_ready;
    logic [3:0] enc_in_data = '0;
    logic       enc_out_valid;
    logic       enc_out_ready = 1'b1;
    logic [6:0] enc_out_code;
    logic       dec_in_valid = 1'b0;
    logic       dec_in_ready;
    logic [6:0] dec_in_code = '0;
    logic       dec_out_valid;
    logic       dec_out_ready = 1'b1;
    logic [3:0] dec_out_data;
    logic [2:0] dec_out_synd;
    logic       dec_out_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ham74_codec dut_i (.*);

    // {data, expected codeword}  (R1)
    localparam logic [10:0] ENC_VEC [5] = '{
        {4'b1011, 7'b1010100},
        {4'b0000, 7'b0000000},
        {4'b1111, 7'b1111111},
        {4'b0001, 7'b0000111},
        {4'b1000, 7'b1001010}
    };
    // {received word, expected data, expected syndrome}  (R3, R4, R6)
    localparam logic [13:0] DEC_VEC [5] = '{
        {7'b1000100, 4'b1011, 3'b101},
        {7'b1010100, 4'b1011, 3'b000},
        {7'b1111111, 4'b1111, 3'b000},
        {7'b0000001, 4'b0000, 3'b001},
        {7'b0100000, 4'b0000, 3'b111}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_code(input logic [3:0] d);
        return {d[3], d[2], d[1], d[3]^d[2]^d[1], d[0], d[3]^d[2]^d[0], d[2]^d[1]^d[0]};
    endfunction

    function automatic logic [2:0] ref_sig(input int b);
        case (b)
            6: return 3'b110;
            5: return 3'b111;
            4: return 3'b101;
            3: return 3'b100;
            2: return 3'b011;
            1: return 3'b010;
            default: return 3'b001;
        endcase
    endfunction

    // Offer one word on both paths and sample at the following falling edge
    task automatic push(input logic [3:0] d, input logic [6:0] rx);
        @(negedge clk);
        enc_in_valid = 1'b1; enc_in_data = d;
        dec_in_valid = 1'b1; dec_in_code = rx;
        @(negedge clk);
        enc_in_valid = 1'b0; dec_in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(!enc_out_valid && !dec_out_valid, "R8 valids", {enc_out_valid, dec_out_valid}, 0);
        chk(enc_in_ready && dec_in_ready, "R8 readies", {enc_in_ready, dec_in_ready}, 3);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 5; i++) begin
            push(ENC_VEC[i][10:7], DEC_VEC[i][13:7]);
            chk(enc_out_valid, "R7 enc valid", enc_out_valid, 1);
            chk(enc_out_code == ENC_VEC[i][6:0], "R1 code", enc_out_code, ENC_VEC[i][6:0]);
            chk(dec_out_valid, "R7 dec valid", dec_out_valid, 1);
            chk(dec_out_data == DEC_VEC[i][6:3], "R6/R4 data", dec_out_data, DEC_VEC[i][6:3]);
            chk(dec_out_synd == DEC_VEC[i][2:0], "R3 synd", dec_out_synd, DEC_VEC[i][2:0]);
            chk(dec_out_err == (DEC_VEC[i][2:0] != 0), "R5 err", dec_out_err, DEC_VEC[i][2:0] != 0);
        end

        // Exhaustive: 16 data values x 7 single flips, plus clean words
        for (int d = 0; d < 16; d++) begin
            push(4'(d), ref_code(4'(d)));
            chk(enc_out_code == ref_code(4'(d)), "R1 code all", enc_out_code, ref_code(4'(d)));
            chk(dec_out_data == 4'(d) && !dec_out_err, "R3 clean", dec_out_data, d);
            for (int b = 0; b < 7; b++) begin
                push(4'(d), ref_code(4'(d)) ^ (7'b1 << b));
                chk(dec_out_data == 4'(d), "R4 data", dec_out_data, d);
                chk(dec_out_synd == ref_sig(b), "R4 synd", dec_out_synd, ref_sig(b));
                chk(dec_out_err, "R5 err set", dec_out_err, 1);
            end
        end
        @(negedge clk);
        chk(!enc_out_valid && !dec_out_valid, "R7 drain", {enc_out_valid, dec_out_valid}, 0);

        // Stall both paths
        enc_out_ready = 1'b0; dec_out_ready = 1'b0;
        push(4'b1011, 7'b1000100);
        enc_in_valid = 1'b1; enc_in_data = 4'b0001;
        dec_in_valid = 1'b1; dec_in_code = 7'b0000111;
        #1;
        chk(!enc_in_ready, "R2 enc blocked", enc_in_ready, 0);
        chk(!dec_in_ready, "R9 dec blocked", dec_in_ready, 0);
        @(negedge clk);
        chk(enc_out_valid && enc_out_code == 7'b1010100, "R2 enc hold", enc_out_code, 7'b1010100);
        chk(dec_out_valid && dec_out_data == 4'b1011 && dec_out_synd == 3'b101 && dec_out_err,
            "R9 dec hold", {dec_out_data, dec_out_synd}, {4'b1011, 3'b101});
        // Release: waiting word is taken at the same edge
        enc_out_ready = 1'b1; dec_out_ready = 1'b1;
        #1;
        chk(enc_in_ready && dec_in_ready, "R7 ready on drain", {enc_in_ready, dec_in_ready}, 3);
        @(negedge clk);
        enc_in_valid = 1'b0; dec_in_valid = 1'b0;
        chk(enc_out_valid && enc_out_code == 7'b0000111, "R7 enc next", enc_out_code, 7'b0000111);
        chk(dec_out_valid && dec_out_data == 4'b0001 && !dec_out_err, "R7 dec next", dec_out_data, 1);

        // Reset with words held
        enc_out_ready = 1'b0; dec_out_ready = 1'b0;
        push(4'b1111, 7'b1111111);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(!enc_out_valid && !dec_out_valid, "R8 mid reset", {enc_out_valid, dec_out_valid}, 0);
        chk(enc_in_ready && dec_in_ready, "R8 mid ready", {enc_in_ready, dec_in_ready}, 3);
        finish_run();
    end

endmodule